// File: doc/BRIEF.md
# Debug command frame sequencer

This block sits between a serial bit engine and the on-chip resources of a debug port. It runs whole debug transactions. It takes an 8-bit command from the engine and decides the command's class from its top three bits. Depending on the class, it then collects a 16-bit address and/or a 16-bit data word, or hands a 16-bit result back to the engine for transmission. Each class waits a fixed number of bus clock cycles at its own point in the frame. While that wait runs, the engine cannot hand over a new item.

Hardware reads and writes become a single-beat request on a local memory port. The request is held until it is acknowledged. Firmware-class and go/trace commands are passed on as a one-cycle strobe carrying the command byte and any write data. Firmware reads return a word sampled from a firmware data input. A timeout from the bit engine abandons the frame at any point.

Top module: `dbg_frame_seq`

## Requirements
- R1: After reset, rx_ready_o=1, rx_word_o=0, and tx_valid_o, bus_req_o and fw_valid_o are all 0.
- R2: The command byte is taken from rx_data_i[7:0] while rx_word_o=0. If bit 7 is 1, the command is a hardware access, bit 5 selects write (1) or read (0), and bit 6 is ignored. If bits 7:6 are 01, the command is a firmware access, with bit 5 selecting write or read. If bits 7:6 are 00, the command is go/trace. After a hardware command, rx_word_o=1 while the next item (the address) is awaited.
- R3: Hardware read: command, then address. On the address a bus read is issued (bus_we_o=0). Exactly 150 cycles after the address is accepted, tx_valid_o rises with the read data. tx_data_o then holds until tx_done_i.
- R4: Hardware write: command, address, then data. On the data a bus write is issued (bus_we_o=1) with that address and data. The next command is accepted 150 cycles later.
- R5: Firmware write: command, then data. A one-cycle fw_valid_o pulse carries the command on fw_cmd_o and the data on fw_data_o. The next command is accepted 36 cycles after the data.
- R6: Firmware read: on the command, fw_valid_o pulses. After 76 cycles, tx_valid_o rises with fw_rdata_i as sampled at the end of the wait.
- R7: Go/trace: on the command, fw_valid_o pulses with that command. No address or data is collected. The next command is accepted 76 cycles later.
- R8: While a wait runs, rx_ready_o is 0 and rx_valid_i is ignored. Afterwards a command (not a word) is awaited.
- R9: bus_req_o and bus_addr_o hold until bus_ack_i. If the acknowledge comes late, the wait is extended until it arrives.
- R10: A timeout_i pulse returns the block to command wait (rx_ready_o=1, rx_word_o=0) on the next cycle, and drops tx_valid_o and bus_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received item available from bit engine |
| rx_data_i | input | 16 | Received item (command in low byte) |
| rx_ready_o | output | 1 | Sequencer accepts an item this cycle |
| rx_word_o | output | 1 | Item awaited is 16 bits (1) or a command byte (0) |
| timeout_i | input | 1 | Bit engine timeout, abandons the frame |
| tx_valid_o | output | 1 | Word ready for the engine to send |
| tx_data_o | output | 16 | Word to send |
| tx_done_i | input | 1 | Engine finished sending the word |
| bus_req_o | output | 1 | Local bus request |
| bus_we_o | output | 1 | Request is a write |
| bus_addr_o | output | 16 | Request address |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Request completed |
| bus_rdata_i | input | 16 | Read data, valid with bus_ack_i |
| fw_valid_o | output | 1 | One-cycle firmware/go command strobe |
| fw_cmd_o | output | 8 | Command byte for the strobe |
| fw_data_o | output | 16 | Firmware write data |
| fw_rdata_i | input | 16 | Firmware read result |

## Verification
The bench measures each wait to the exact cycle, counting from the acceptance of the last received item. A counter that is off by one, or a wait placed at the wrong point in the frame, shows up as a wrong count or as an extra item being requested.

Command bytes with the ignored bit 6 set, and a go/trace byte with bit 5 set, catch a decoder that uses the wrong bit order. Such a decoder routes the frame down another class, and both the wait and the items requested come out wrong.

Garbage is held on rx_valid_i during a wait. A design that accepted it would then ask for a 16-bit item instead of a command. A late bus acknowledge shows whether the wait is extended or whether stale read data is returned. Timeouts are sent mid-address and mid-wait; a design that ignored them would keep waiting, or keep asking for words.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [2:0] {CLS_HW_RD, CLS_HW_WR, CLS_FW_RD, CLS_FW_WR, CLS_GO} cls_e;
  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_DATA, ST_DLY, ST_TX} st_e;
endpackage

// File: rtl/dbg_seq_decode.sv
module dbg_seq_decode
  import dbg_seq_pkg::*;
(
  input  logic [2:0] top_bits_i,  // command bits {7,6,5}
  output cls_e       cls_o
);
  always_comb begin
    if (top_bits_i[2])      cls_o = top_bits_i[0] ? CLS_HW_WR : CLS_HW_RD;
    else if (top_bits_i[1]) cls_o = top_bits_i[0] ? CLS_FW_WR : CLS_FW_RD;
    else                    cls_o = CLS_GO;
  end
endmodule

// File: rtl/dbg_seq_delay.sv
module dbg_seq_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] len_i,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dbg_seq_bus.sv
module dbg_seq_bus #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              abort_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [WORD_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [WORD_W-1:0] bus_rdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic              req_q, we_q;
  logic [WORD_W-1:0] addr_q, wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (req_q && bus_ack_i && !we_q) rdata_q <= bus_rdata_i;
      if (abort_i) req_q <= 1'b0;
      else if (start_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (bus_ack_i) req_q <= 1'b0;
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;

  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !abort_i) |=> (bus_req_o && $stable(bus_addr_o))); // R9
endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
  import dbg_seq_pkg::*;
#(
  parameter int CMD_W     = 8,
  parameter int WORD_W    = 16,
  parameter int DLY_W     = 8,
  parameter int HW_DLY    = 150,
  parameter int FW_WR_DLY = 36,
  parameter int FW_RD_DLY = 76,
  parameter int GO_DLY    = 76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              rx_word_o,
  input  logic              timeout_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_data_o,
  input  logic              tx_done_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [WORD_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [WORD_W-1:0] bus_rdata_i,
  output logic              fw_valid_o,
  output logic [CMD_W-1:0]  fw_cmd_o,
  output logic [WORD_W-1:0] fw_data_o,
  input  logic [WORD_W-1:0] fw_rdata_i
);
  localparam logic [DLY_W-1:0] HW_LEN = DLY_W'(HW_DLY);
  localparam logic [DLY_W-1:0] FWW_LEN = DLY_W'(FW_WR_DLY);
  localparam logic [DLY_W-1:0] FWR_LEN = DLY_W'(FW_RD_DLY);
  localparam logic [DLY_W-1:0] GO_LEN = DLY_W'(GO_DLY);

  st_e               st_q, st_d;
  cls_e              cls_q, cls_now;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] addr_q, fw_data_q, tx_q, bus_rd, bus_addr_d;
  logic              fw_valid_q, fw_fire, tx_load, acc;
  logic              dly_load, dly_done, bus_start, bus_we_d;
  logic [DLY_W-1:0]  dly_len;

  dbg_seq_decode u_dec (
    .top_bits_i(rx_data_i[CMD_W-1 -: 3]),
    .cls_o     (cls_now)
  );

  dbg_seq_delay #(.DLY_W(DLY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(dly_load),
    .len_i (dly_len),
    .done_o(dly_done)
  );

  dbg_seq_bus #(.WORD_W(WORD_W)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (bus_start),
    .we_i       (bus_we_d),
    .addr_i     (bus_addr_d),
    .wdata_i    (rx_data_i),
    .abort_i    (timeout_i),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i),
    .bus_rdata_i(bus_rdata_i),
    .rdata_o    (bus_rd)
  );

  assign rx_ready_o = (st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign rx_word_o  = (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign acc        = rx_valid_i && rx_ready_o;
  assign tx_valid_o = (st_q == ST_TX);
  assign tx_data_o  = tx_q;
  assign fw_valid_o = fw_valid_q;
  assign fw_cmd_o   = cmd_q;
  assign fw_data_o  = fw_data_q;

  always_comb begin
    st_d       = st_q;
    dly_load   = 1'b0;
    dly_len    = HW_LEN;
    bus_start  = 1'b0;
    bus_we_d   = 1'b0;
    bus_addr_d = addr_q;
    fw_fire    = 1'b0;
    tx_load    = 1'b0;
    case (st_q)
      ST_CMD: if (acc) begin
        case (cls_now)
          CLS_HW_RD, CLS_HW_WR: st_d = ST_ADDR;
          CLS_FW_WR:            st_d = ST_DATA;
          CLS_FW_RD: begin st_d = ST_DLY; dly_load = 1'b1; dly_len = FWR_LEN; fw_fire = 1'b1; end
          default:   begin st_d = ST_DLY; dly_load = 1'b1; dly_len = GO_LEN;  fw_fire = 1'b1; end
        endcase
      end
      ST_ADDR: if (acc) begin
        if (cls_q == CLS_HW_WR) st_d = ST_DATA;
        else begin
          st_d       = ST_DLY;
          dly_load   = 1'b1;
          bus_start  = 1'b1;
          bus_addr_d = rx_data_i;
        end
      end
      ST_DATA: if (acc) begin
        st_d     = ST_DLY;
        dly_load = 1'b1;
        if (cls_q == CLS_HW_WR) begin
          bus_start = 1'b1;
          bus_we_d  = 1'b1;
        end else begin
          fw_fire = 1'b1;
          dly_len = FWW_LEN;
        end
      end
      ST_DLY: if (dly_done && !bus_req_o) begin
        // wait ends only when both the count and the bus reply are in
        tx_load = (cls_q == CLS_HW_RD) || (cls_q == CLS_FW_RD);
        st_d    = tx_load ? ST_TX : ST_CMD;
      end
      ST_TX: if (tx_done_i) st_d = ST_CMD;
      default: st_d = ST_CMD;
    endcase
    if (timeout_i) st_d = ST_CMD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CMD;
      cls_q      <= CLS_GO;
      cmd_q      <= '0;
      addr_q     <= '0;
      fw_data_q  <= '0;
      tx_q       <= '0;
      fw_valid_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      fw_valid_q <= fw_fire && !timeout_i;
      if (st_q == ST_CMD && acc) begin
        cmd_q <= rx_data_i[CMD_W-1:0];
        cls_q <= cls_now;
      end
      if (st_q == ST_ADDR && acc) addr_q <= rx_data_i;
      if (st_q == ST_DATA && acc) fw_data_q <= rx_data_i;
      if (tx_load) tx_q <= (cls_q == CLS_HW_RD) ? bus_rd : fw_rdata_i;
    end
  end

  AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> (rx_ready_o && !rx_word_o && !tx_valid_o && !bus_req_o)); // R10
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_done_i && !timeout_i) |=> (tx_valid_o && $stable(tx_data_o))); // R3
  AST_TX_AFTER_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(dly_done)); // R6
  AST_FW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_valid_o |=> !fw_valid_o); // R5
  AST_NO_RX_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !tx_valid_o) |-> !rx_ready_o); // R8
endmodule

// File: tb/dbg_frame_seq_tb.sv
module dbg_frame_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0, timeout_i = 1'b0, tx_done_i = 1'b0, bus_ack_i = 1'b0;
  logic [15:0] rx_data_i = '0, bus_rdata_i = '0, fw_rdata_i = '0;
  logic        rx_ready_o, rx_word_o, tx_valid_o, bus_req_o, bus_we_o, fw_valid_o;
  logic [15:0] tx_data_o, bus_addr_o, bus_wdata_o, fw_data_o;
  logic [7:0]  fw_cmd_o;

  int errors = 0, checks = 0;
  int ack_n = 0, fw_n = 0, ack_wait = 0, slow_ack = 0;
  logic        cap_we;
  logic [15:0] cap_addr, cap_wdata, fw_dat_c;
  logic [7:0]  fw_cmd_c;

  // {cmd, addr, data, wait, expected tx word}
  localparam logic [63:0] VECS [0:6] = '{
    {8'h84, 16'h1234, 16'h0000, 8'd150, 16'hEDCB},
    {8'hA2, 16'h2000, 16'hBEEF, 8'd150, 16'h0000},
    {8'h44, 16'h0000, 16'h0000, 8'd76,  16'hF044},
    {8'h62, 16'h0000, 16'h5A5A, 8'd36,  16'h0000},
    {8'h08, 16'h0000, 16'h0000, 8'd76,  16'h0000},
    {8'hC7, 16'hFFFF, 16'h0000, 8'd150, 16'h0000},
    {8'h30, 16'h0000, 16'h0000, 8'd76,  16'h0000}
  };

  dbg_frame_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o), .rx_word_o(rx_word_o),
    .timeout_i(timeout_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_done_i(tx_done_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .fw_valid_o(fw_valid_o), .fw_cmd_o(fw_cmd_o), .fw_data_o(fw_data_o), .fw_rdata_i(fw_rdata_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus responder and firmware strobe monitor, both off the active edge
  always @(negedge clk) begin
    if (fw_valid_o) begin
      fw_n++;
      fw_cmd_c = fw_cmd_o;
      fw_dat_c = fw_data_o;
    end
    if (!rst_ni) bus_ack_i = 1'b0;
    else if (bus_req_o && !bus_ack_i) begin
      if (ack_wait >= slow_ack) begin
        bus_ack_i   = 1'b1;
        bus_rdata_i = ~bus_addr_o;
        cap_addr    = bus_addr_o;
        cap_we      = bus_we_o;
        cap_wdata   = bus_wdata_o;
        ack_n++;
        ack_wait = 0;
      end else ack_wait++;
    end else bus_ack_i = 1'b0;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk);
    while (!rx_ready_o) @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(posedge clk);
    #1 rx_valid_i = 1'b0;
  endtask

  task automatic wait_end(output int n);
    n = 0;
    @(negedge clk);
    while (!(rx_ready_o || tx_valid_o)) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_tx();
    tx_done_i = 1'b1;
    @(posedge clk);
    #1 tx_done_i = 1'b0;
  endtask

  task automatic pulse_timeout();
    @(negedge clk);
    timeout_i = 1'b1;
    @(posedge clk);
    #1 timeout_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 rx_ready", rx_ready_o, 1);
    chk("R1 rx_word", rx_word_o, 0);
    chk("R1 idle outs", {tx_valid_o, bus_req_o, fw_valid_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 7; i++) begin
      logic [7:0]  cmd;
      logic        is_hw, is_wr, is_rd, has_data;
      string       rq;
      cmd      = VECS[i][63:56];
      is_hw    = cmd[7];
      is_wr    = cmd[5] && (cmd[7] || cmd[6]);
      is_rd    = !cmd[5] && (cmd[7] || cmd[6]);
      has_data = is_wr;
      rq = cmd[7] ? (cmd[5] ? "R4" : "R3") : cmd[6] ? (cmd[5] ? "R5" : "R6") : "R7";
      fw_rdata_i = 16'hF000 | {8'h00, cmd};
      ack_n = 0;
      fw_n  = 0;
      send({8'h00, cmd});
      if (is_hw) begin
        @(negedge clk);
        chk("R2 address awaited", rx_word_o, 1);
        send(VECS[i][55:40]);
      end
      if (has_data) send(VECS[i][39:24]);
      wait_end(n);
      chk({rq, " wait"}, n, VECS[i][23:16]);
      chk({rq, " tx_valid"}, tx_valid_o, is_rd);
      if (is_rd) begin
        chk({rq, " tx_data"}, tx_data_o, VECS[i][15:0]);
        finish_tx();
      end
      if (is_hw) begin
        chk({rq, " bus count"}, ack_n, 1);
        chk({rq, " bus addr"}, cap_addr, VECS[i][55:40]);
        chk({rq, " bus we"}, cap_we, cmd[5]);
        if (is_wr) chk({rq, " bus wdata"}, cap_wdata, VECS[i][39:24]);
      end else begin
        chk({rq, " fw strobe"}, fw_n, 1);
        chk({rq, " fw cmd"}, fw_cmd_c, cmd);
        if (is_wr) chk({rq, " fw data"}, fw_dat_c, VECS[i][39:24]);
        chk({rq, " no bus"}, ack_n, 0);
      end
    end

    // R8: garbage held on rx during a wait is not taken
    send(16'h00A2); send(16'h3000); send(16'h1111);
    rx_valid_i = 1'b1;
    rx_data_i  = 16'h0084;
    n = 0;
    @(negedge clk);
    while (!rx_ready_o) begin
      n++;
      @(negedge clk);
    end
    rx_valid_i = 1'b0;
    chk("R8 wait unchanged", n, 150);
    @(negedge clk);
    chk("R8 command awaited", rx_word_o, 0);

    // R9: late acknowledge stretches the wait and returns the right data
    slow_ack = 200;
    ack_n = 0;
    send(16'h0084); send(16'h0F0F);
    wait_end(n);
    chk("R9 wait stretched", (n > 150 && n < 260), 1);
    chk("R9 tx_data", tx_data_o, 16'hF0F0);
    chk("R9 single request", ack_n, 1);
    finish_tx();
    slow_ack = 0;

    // R10: timeout in mid-address and in mid-wait
    send(16'h00A2);
    @(negedge clk);
    chk("R10 pre addr", rx_word_o, 1);
    pulse_timeout();
    chk("R10 addr abort", {rx_ready_o, rx_word_o}, 2'b10);
    send(16'h0084); send(16'h0100);
    repeat (10) @(negedge clk);
    pulse_timeout();
    chk("R10 wait abort", {rx_ready_o, rx_word_o, tx_valid_o, bus_req_o}, 4'b1000);
    send(16'h0008);
    wait_end(n);
    chk("R10 recovers", n, 76);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule